// File: doc/BRIEF.md
# Sine PWM H-Bridge Gate Driver

This block produces the four gate signals of a single-phase full-bridge inverter. The output half-cycle is cut into table steps. At each step a stored half-sine value becomes the duty of a fixed-period PWM carrier. On each side of the bridge, the upper switch is held on as a square wave for the whole half-cycle. The lower switch on the other side carries the sine-modulated pulse train. When a half-cycle ends, the gates rest for a short dead interval, and then the roles of the two sides swap.

One select input picks either the 50 Hz table (40 entries) or the 60 Hz table (42 entries). Each table step lasts a whole number of carrier periods. The 50 Hz mode holds each entry for 5 periods and the 60 Hz mode for 4. A fault input or a low enable blanks every gate at once. Once the block is clear again it starts a fresh half-cycle from the first table entry. A one-cycle marker flags the first clock of every half-cycle.

Top module: `spwm_hbridge_driver`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all four gate outputs and `half_start` are 0.
- R2: Entry k of a table of length N is the 8-bit value floor(4080·k·(N−k) / (5·N² − 4·k·(N−k))). This is a rational half-sine of peak 255: entry 0 is 0 and the middle entry is 255.
- R3: During table entry e, the carrier counter c runs from 0 to PERIOD−1. The PWM level is high exactly when c·256 < e·PERIOD, so each period starts with ceil(e·PERIOD/256) high clocks.
- R4: `mode_sel`=0 selects the 40-entry table with each entry held for 5 carrier periods. `mode_sel`=1 selects the 42-entry table with each entry held for 4 periods. The entry index steps by one and never skips.
- R5: In a running half-cycle exactly one upper gate is high. With polarity A, `gate_hi_a`=1 and `gate_lo_b` carries the PWM. With polarity B, `gate_hi_b`=1 and `gate_lo_a` carries the PWM. The other lower gate stays 0, and polarity alternates on every new half-cycle, starting with A.
- R6: Between two half-cycles all four gates are 0 for DEAD_CYC clocks (at least 2). No upper gate rises unless every gate was 0 in the cycle before.
- R7: When `fault` is 1 or `enable` is 0, all four gates are 0 in the same cycle. After the block is released it spends 1 idle clock and DEAD_CYC dead clocks. It then begins a half-cycle at entry 0 with the polarity flipped.
- R8: `mode_sel` is sampled only when a half-cycle begins. A change in the middle of a half-cycle does not alter that half-cycle's length.
- R9: `half_start` is a single-cycle pulse, high in the first clock of each half-cycle (entry 0, carrier count 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run permission; 0 blanks the gates |
| fault | input | 1 | Fault request; 1 blanks the gates |
| mode_sel | input | 1 | 0: 50 Hz table, 1: 60 Hz table |
| gate_hi_a | output | 1 | Upper switch, side A |
| gate_lo_a | output | 1 | Lower switch, side A |
| gate_hi_b | output | 1 | Upper switch, side B |
| gate_lo_b | output | 1 | Lower switch, side B |
| half_start | output | 1 | Pulse at the first clock of a half-cycle |

## Verification
The assertions assume that `enable`, `fault` and `mode_sel` are synchronous to `clk`, so the blanking relation can be sampled at the edge. The bench changes these inputs one nanosecond after a falling edge and keeps them steady across the next rising edge. Faults and disables are asserted mid-run and released on chosen cycles, so restart timing, the dead gap and the alternation of polarity can be checked against the reference model. Mode changes are applied only mid-half-cycle or just after a half-cycle start, so that the sampling rule of R8 is seen through the spacing of the markers.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEAD = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_t;

  // Rational half-sine, peak 255 at k = n/2 (R2)
  function automatic int unsigned sine_code(int unsigned k, int unsigned n);
    int unsigned a;
    a = k * (n - k);
    return (4080 * a) / (5 * n * n - 4 * a);
  endfunction

  // Carrier compare: high while cnt/period < duty/256 (R3)
  function automatic logic pwm_high(int unsigned cnt, int unsigned duty,
                                    int unsigned period);
    return (cnt * 256) < (duty * period);
  endfunction

  function automatic int max_i(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spwm_sine_rom.sv
module spwm_sine_rom #(
  parameter int N     = 40,
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       duty
);
  logic [7:0] rom [N];

  for (genvar g = 0; g < N; g++) begin : g_rom
    assign rom[g] = 8'(spwm_pkg::sine_code(g, N));
  end

  always_comb begin
    if (int'(idx) < N) duty = rom[idx];
    else               duty = '0;
  end
endmodule

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int PERIOD = 5000,
  parameter int CNT_W  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = run && (cnt == CNT_W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (!run || wrap) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spwm_phase_seq.sv
module spwm_phase_seq #(
  parameter int N50      = 40,
  parameter int N60      = 42,
  parameter int HOLD50   = 5,
  parameter int HOLD60   = 4,
  parameter int DEAD_CYC = 4,
  parameter int IDX_W    = 6,
  parameter int HOLD_W   = 3,
  parameter int DEAD_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ok,
  input  logic             mode_sel,
  input  logic             wrap,
  output logic             run,
  output logic             pol,
  output logic             mode_q,
  output logic [IDX_W-1:0] idx,
  output logic             start
);
  import spwm_pkg::*;

  seq_state_t        state;
  logic [HOLD_W-1:0] hold;
  logic [DEAD_W-1:0] dcnt;
  logic [IDX_W-1:0]  n_last;
  logic [HOLD_W-1:0] h_last;
  logic              dead_done;

  assign n_last    = mode_q ? IDX_W'(N60 - 1)   : IDX_W'(N50 - 1);
  assign h_last    = mode_q ? HOLD_W'(HOLD60 - 1) : HOLD_W'(HOLD50 - 1);
  assign dead_done = (dcnt == DEAD_W'(DEAD_CYC - 1));
  assign run       = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      pol    <= 1'b1;
      mode_q <= 1'b0;
      idx    <= '0;
      hold   <= '0;
      dcnt   <= '0;
      start  <= 1'b0;
    end else if (!ok) begin
      state <= ST_IDLE;
      start <= 1'b0;
    end else begin
      start <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          state <= ST_DEAD;
          dcnt  <= '0;
        end
        ST_DEAD: begin
          if (dead_done) begin
            state  <= ST_RUN;
            pol    <= ~pol;
            mode_q <= mode_sel;
            idx    <= '0;
            hold   <= '0;
            start  <= 1'b1;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (wrap) begin
            if (hold == h_last) begin
              hold <= '0;
              if (idx == n_last) begin
                state <= ST_DEAD;
                dcnt  <= '0;
              end else begin
                idx <= idx + 1'b1;
              end
            end else begin
              hold <= hold + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spwm_gate_mux.sv
module spwm_gate_mux (
  input  logic active,
  input  logic pol,
  input  logic pwm,
  output logic hi_a,
  output logic lo_a,
  output logic hi_b,
  output logic lo_b
);
  always_comb begin
    hi_a = active && !pol;
    lo_b = active && !pol && pwm;
    hi_b = active && pol;
    lo_a = active && pol && pwm;
  end
endmodule

// File: rtl/spwm_hbridge_driver.sv
module spwm_hbridge_driver #(
  parameter int PERIOD   = 5000,
  parameter int N50      = 40,
  parameter int N60      = 42,
  parameter int HOLD50   = 5,
  parameter int HOLD60   = 4,
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic fault,
  input  logic mode_sel,
  output logic gate_hi_a,
  output logic gate_lo_a,
  output logic gate_hi_b,
  output logic gate_lo_b,
  output logic half_start
);
  import spwm_pkg::*;

  localparam int NMAX   = max_i(N50, N60);
  localparam int HMAX   = max_i(HOLD50, HOLD60);
  localparam int IDX_W  = max_i(1, $clog2(NMAX));
  localparam int HOLD_W = max_i(1, $clog2(HMAX));
  localparam int DEAD_W = max_i(1, $clog2(DEAD_CYC));
  localparam int CNT_W  = max_i(1, $clog2(PERIOD));

  logic             ok;
  logic             run_ok;
  logic             seq_run;
  logic             seq_pol;
  logic             seq_mode;
  logic [IDX_W-1:0] seq_idx;
  logic [CNT_W-1:0] car_cnt;
  logic             car_wrap;
  logic [7:0]       duty50;
  logic [7:0]       duty60;
  logic [7:0]       duty;
  logic             pwm;

  assign ok     = enable && !fault;
  assign run_ok = seq_run && ok;

  spwm_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) carrier_i (
    .clk (clk), .rst (rst), .run (run_ok), .cnt (car_cnt), .wrap (car_wrap)
  );

  spwm_phase_seq #(
    .N50(N50), .N60(N60), .HOLD50(HOLD50), .HOLD60(HOLD60),
    .DEAD_CYC(DEAD_CYC), .IDX_W(IDX_W), .HOLD_W(HOLD_W), .DEAD_W(DEAD_W)
  ) seq_i (
    .clk (clk), .rst (rst), .ok (ok), .mode_sel (mode_sel), .wrap (car_wrap),
    .run (seq_run), .pol (seq_pol), .mode_q (seq_mode), .idx (seq_idx),
    .start (half_start)
  );

  spwm_sine_rom #(.N(N50), .IDX_W(IDX_W)) rom50_i (.idx (seq_idx), .duty (duty50));
  spwm_sine_rom #(.N(N60), .IDX_W(IDX_W)) rom60_i (.idx (seq_idx), .duty (duty60));

  assign duty = seq_mode ? duty60 : duty50;
  assign pwm  = pwm_high(32'(car_cnt), 32'(duty), PERIOD);

  spwm_gate_mux mux_i (
    .active (run_ok), .pol (seq_pol), .pwm (pwm),
    .hi_a (gate_hi_a), .lo_a (gate_lo_a), .hi_b (gate_hi_b), .lo_b (gate_lo_b)
  );
endmodule

// File: rtl/spwm_hbridge_checker.sv
module spwm_hbridge_checker #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             fault,
  input logic             hi_a,
  input logic             lo_a,
  input logic             hi_b,
  input logic             lo_b,
  input logic             half_start,
  input logic             run_q,
  input logic             mode_q,
  input logic [IDX_W-1:0] idx
);
  logic [3:0] gates;
  assign gates = {hi_a, lo_a, hi_b, lo_b};

  assert_blank_on_fault_R7: assert property (@(posedge clk) disable iff (rst)
    (fault || !enable) |-> (gates == 4'b0000));

  assert_no_shoot_through_R5: assert property (@(posedge clk) disable iff (rst)
    !(hi_a && lo_a) && !(hi_b && lo_b));

  assert_single_upper_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hi_a, hi_b}));

  assert_dead_before_upper_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(hi_a) || $rose(hi_b)) |-> ($past(gates) == 4'b0000));

  assert_marker_single_R9: assert property (@(posedge clk) disable iff (rst)
    half_start |=> !half_start);

  assert_marker_at_entry0_R9: assert property (@(posedge clk) disable iff (rst)
    half_start |-> (run_q && idx == '0));

  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (run_q && !half_start) |-> $stable(mode_q));

  assert_index_step_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && !half_start) |-> (idx == $past(idx) || idx == IDX_W'($past(idx) + 1'b1)));
endmodule

bind spwm_hbridge_driver spwm_hbridge_checker #(.IDX_W(IDX_W)) chk_i (
  .clk (clk), .rst (rst), .enable (enable), .fault (fault),
  .hi_a (gate_hi_a), .lo_a (gate_lo_a), .hi_b (gate_hi_b), .lo_b (gate_lo_b),
  .half_start (half_start), .run_q (seq_run), .mode_q (seq_mode), .idx (seq_idx)
);

// File: tb/spwm_hbridge_driver_tb.sv
`timescale 1ns/1ps
module spwm_hbridge_driver_tb_top;
  localparam int P = 16;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic fault = 1'b0;
  logic mode_sel = 1'b0;
  logic hi_a, lo_a, hi_b, lo_b, half_start;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  spwm_hbridge_driver #(.PERIOD(P), .DEAD_CYC(D)) dut_i (
    .clk (clk), .rst (rst), .enable (enable), .fault (fault), .mode_sel (mode_sel),
    .gate_hi_a (hi_a), .gate_lo_a (lo_a), .gate_hi_b (hi_b), .gate_lo_b (lo_b),
    .half_start (half_start)
  );

  task automatic chk(bit good, string tag, int act, int exp);
    vectors++;
    if (!good) begin
      miscompares++;
      $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_entry(int k, int n);
    int p = k * (n - k);
    return (255 * 16 * p) / (5 * n * n - 4 * p);
  endfunction
  function automatic int high_clocks(int e);
    return (e * P + 255) / 256;
  endfunction
  function automatic int tab_len(int m);  return m ? 42 : 40; endfunction
  function automatic int step_len(int m); return m ? 4 : 5;   endfunction

  // Behavioural reference: 0 idle, 1 dead, 2 running
  int m_state = 0, m_dc = 0, m_t = 0, m_mode = 0;
  bit m_pol = 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_state = 0; m_pol = 1'b1; m_mode = 0; m_t = 0; m_dc = 0;
    end else if (!enable || fault) begin
      m_state = 0;
    end else begin
      case (m_state)
        0: begin m_state = 1; m_dc = 0; end
        1: if (m_dc == D - 1) begin
             m_state = 2; m_pol = !m_pol; m_mode = int'(mode_sel); m_t = 0;
           end else m_dc++;
        default:
          if (m_t == tab_len(m_mode) * step_len(m_mode) * P - 1) begin
            m_state = 1; m_dc = 0;
          end else m_t++;
      endcase
    end
  end

  int acc = 0;
  always @(negedge clk) begin
    bit okn;
    int k, c, e;
    bit pw;
    logic [3:0] exp_g, act_g;
    string tag;
    okn = enable && !fault && !rst;
    exp_g = 4'b0000; pw = 1'b0; c = 0; e = 0;
    if (okn && m_state == 2) begin
      k = m_t / (P * step_len(m_mode));
      c = m_t % P;
      e = ref_entry(k, tab_len(m_mode));
      pw = (c < high_clocks(e));
      if (!m_pol) exp_g = {1'b1, 1'b0, 1'b0, pw};
      else        exp_g = {1'b0, pw, 1'b1, 1'b0};
    end
    act_g = {hi_a, lo_a, hi_b, lo_b};
    if (rst) tag = "R1";
    else if (!okn || m_state == 0) tag = "R7";
    else if (m_state == 1) tag = "R6";
    else tag = "R5";
    chk(act_g === exp_g, {tag, " gates{hi_a,lo_a,hi_b,lo_b}"}, int'(act_g), int'(exp_g));
    chk(half_start === (okn && m_state == 2 && m_t == 0), "R9 half_start",
        int'(half_start), int'(okn && m_state == 2 && m_t == 0));
    if (okn && m_state == 2) begin
      if (c == 0) acc = 0;
      acc += (m_pol ? int'(lo_a) : int'(lo_b));
      if (c == P - 1) chk(acc == high_clocks(e), "R2 R3 high clocks per period", acc, high_clocks(e));
    end
  end

  int last_start = 0;
  task automatic wait_start(output int gap, output bit upper_a);
    do @(negedge clk); while (half_start !== 1'b1);
    gap = cyc - last_start;
    last_start = cyc;
    upper_a = hi_a;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int gap, c0;
    bit ua;
    step(1);
    chk({hi_a, lo_a, hi_b, lo_b, half_start} === 5'b0, "R1 outputs in reset", 0, 0);
    step(3);
    rst = 1'b0;
    step(1);
    chk({hi_a, lo_a, hi_b, lo_b, half_start} === 5'b0, "R1 outputs after reset", 0, 0);
    step(4);
    chk({hi_a, lo_a, hi_b, lo_b} === 4'b0, "R7 disabled gates", int'({hi_a, lo_a, hi_b, lo_b}), 0);

    enable = 1'b1; c0 = cyc;
    wait_start(gap, ua);
    chk(cyc - c0 == 1 + D, "R6 idle plus dead before first start", cyc - c0, 1 + D);
    chk(ua == 1'b1, "R5 first polarity A", int'(ua), 1);
    @(negedge clk);
    chk(half_start == 1'b0, "R9 marker one cycle", int'(half_start), 0);
    wait_start(gap, ua);
    chk(gap == 3203, "R4 50Hz half-cycle spacing", gap, 3203);
    chk(ua == 1'b0, "R5 polarity alternates", int'(ua), 0);

    step(600);
    mode_sel = 1'b1;
    wait_start(gap, ua);
    chk(gap == 3203, "R8 mid-cycle mode change ignored", gap, 3203);
    wait_start(gap, ua);
    chk(gap == 2691, "R4 60Hz half-cycle spacing", gap, 2691);

    step(100);
    fault = 1'b1;
    #1;
    chk({hi_a, lo_a, hi_b, lo_b} === 4'b0, "R7 fault blanks same cycle",
        int'({hi_a, lo_a, hi_b, lo_b}), 0);
    step(8);
    fault = 1'b0; c0 = cyc;
    wait_start(gap, ua);
    chk(cyc - c0 == 1 + D, "R7 restart delay after fault", cyc - c0, 1 + D);
    chk(ua == 1'b1, "R7 restart flips polarity", int'(ua), 1);

    step(50);
    enable = 1'b0;
    #1;
    chk({hi_a, lo_a, hi_b, lo_b} === 4'b0, "R7 disable blanks same cycle",
        int'({hi_a, lo_a, hi_b, lo_b}), 0);
    step(10);
    enable = 1'b1;
    wait_start(gap, ua);
    step(1);
    mode_sel = 1'b0;
    wait_start(gap, ua);
    chk(gap == 2691, "R8 change after start waits", gap, 2691);
    wait_start(gap, ua);
    chk(gap == 3203, "R4 back to 50Hz spacing", gap, 3203);

    step(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog all requirements act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule